// File: doc/BRIEF.md
# Converter Sample Capture with Settling Blanking

This block sits on the host side of a parallel-output oversampling converter. It watches the converter's active-low data-ready line through a two-flop synchroniser. On each falling edge it pulses chip-select and read-enable low together for one clock, and on the next clock it latches the 16-bit two's-complement word and the out-of-range flag. The captured sample is presented as a one-clock valid pulse with data and flag.

The converter's digital filter needs time to settle after certain events, so the block discards a number of data-ready cycles after each of them. No read strobe and no valid pulse are issued during that time. Leaving power-down (and coming out of reset) costs 100 cycles. A sync pulse or a change of rate mode costs 55 cycles in normal mode and 13 in double-rate mode. A settled status bit rises when the blanking count runs out. The block can also issue the converter's active-low sync pulse. That pulse changes on falling clock edges, so several converters sharing the clock are reset together. While the pulse runs, data-ready edges are ignored and the blanking count is held at its reload value.

Top module: `adc_capture`

## Requirements
- R1: While reset is low and on the first cycle after it, `rd_cs_n`, `rd_en_n` and `cnv_sync_n` are 1, and `smp_valid` and `settled` are 0.
- R2: When `rdy_n` is first sampled low at clock edge k (after having been high for at least three edges), and the sample is accepted, `rd_cs_n` and `rd_en_n` are both 0 for exactly the clock after edge k+2.
- R3: On an accepted sample, `smp_data` and `smp_ovr` take the values of `bus_data` and `bus_ovr` at edge k+3, and `smp_valid` is 1 for exactly the one clock after edge k+3.
- R4: After reset, and after `pwr_on` returns to 1 from 0, the first 100 data-ready falls are discarded: no strobe and no valid. `settled` is 0 until the 100th fall and 1 from then on, and the 101st fall is accepted.
- R5: After a sync pulse with `dbl_rate`=0, 55 falls are discarded and `settled` rises with the 55th.
- R6: After a sync pulse with `dbl_rate`=1, 13 falls are discarded and `settled` rises with the 13th.
- R7: A change of `dbl_rate` clears `settled` and reloads the blanking count for the new mode (55 for 0, 13 for 1).
- R8: A one-clock `sync_req` sampled at edge e while no pulse is running drives `cnv_sync_n` low from the falling clock edge after e to the falling edge after e+4, which is 4 clocks. A request that arrives during a pulse is ignored.
- R9: The range flag passes through unchanged. The full-scale codes 7FFF and 8000 with the flag at 1, and in-range codes with the flag at 0, appear on `smp_data` and `smp_ovr` as driven.
- R10: A data-ready fall that occurs while the sync pulse is running produces no strobe and no valid, and is not counted toward blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, shared with the converter |
| rst_n | input | 1 | Synchronous active-low reset |
| rdy_n | input | 1 | Converter data-ready, falling edge marks a new word |
| bus_data | input | 16 | Converter parallel output word |
| bus_ovr | input | 1 | Converter out-of-range flag |
| dbl_rate | input | 1 | Rate mode: 0 normal, 1 double rate |
| pwr_on | input | 1 | 0 holds converter in power-down |
| sync_req | input | 1 | Request to issue a sync pulse |
| rd_cs_n | output | 1 | Chip-select to the converter, active low |
| rd_en_n | output | 1 | Read-enable to the converter, active low |
| cnv_sync_n | output | 1 | Sync pulse to the converters, active low, changes on falling clock |
| smp_valid | output | 1 | One-clock pulse with each captured sample |
| smp_data | output | 16 | Captured signed sample |
| smp_ovr | output | 1 | Captured range flag |
| settled | output | 1 | Blanking finished |

## Verification
A blanking counter that is off by one shows up on the last discarded cycle. Either `settled` rises one cycle early or late, or the first accepted fall produces no strobe, and the bench sees this within one data-ready period of the end of blanking. A wrong reload value, such as the normal-mode count used in double-rate mode, is caught on the 14th fall after a sync. A broken synchroniser chain or latch point moves the strobe or valid off its computed clock, and the first accepted sample exposes it. A sync pulse of the wrong length, or one that changes on the rising edge, shows within six clocks of the request.

// File: rtl/adc_cap_pkg.sv
// Shared types for the converter capture block.
// Assumes nothing beyond plain SystemVerilog packages.
package adc_cap_pkg;
    // Read strobe sequencer states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_READ = 1'b1
    } strobe_state_t;

    // Source of a blanking counter reload
    typedef enum logic [1:0] {
        LD_NONE   = 2'd0,
        LD_PWR    = 2'd1,
        LD_RESYNC = 2'd2
    } load_src_t;
endpackage

// File: rtl/adc_cap_edge.sv
// Synchronises the converter's active-low data-ready line and flags its
// falling edge for one clock. Assumes the line idles high.
module adc_cap_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_n,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            // One synchroniser stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else if (g == 0) chain[g] <= rdy_n;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // Delayed copy of the synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/adc_cap_blank.sv
// Settling blanking counter. Reloads on power-down (held while off) and on
// resync events (sync pulse or rate change) with the count for the current
// mode, then counts down one per data-ready fall. Samples are kept only when
// the count is already zero and no reload is pending.
module adc_cap_blank
    import adc_cap_pkg::*;
#(
    parameter int N_NORM = 55,
    parameter int N_DBL  = 13,
    parameter int N_PWR  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    input  logic resync,
    input  logic dbl_rate,
    input  logic fall,
    output logic settled,
    output logic keep
);
    localparam int MAX_A = (N_NORM > N_DBL) ? N_NORM : N_DBL;
    localparam int MAX_N = (MAX_A > N_PWR) ? MAX_A : N_PWR;
    localparam int CW    = $clog2(MAX_N + 1);

    logic [CW-1:0] cnt;
    load_src_t     src;

    // Pick the reload source; power-down wins over a resync
    always_comb begin
        if (!pwr_on)     src = LD_PWR;
        else if (resync) src = LD_RESYNC;
        else             src = LD_NONE;
    end

    // Blanking count: reload or step down on each data-ready fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CW'(N_PWR);
        end else begin
            case (src)
                LD_PWR:    cnt <= CW'(N_PWR);
                LD_RESYNC: cnt <= dbl_rate ? CW'(N_DBL) : CW'(N_NORM);
                default:   if (fall && cnt != '0) cnt <= cnt - 1'b1;
            endcase
        end
    end

    assign settled = (cnt == '0);
    assign keep    = fall && settled && (src == LD_NONE);

    // R4: settled only drops through a reload
    assert_settle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && pwr_on && !resync) |=> settled);
    // R7: any reload leaves the block unsettled on the next cycle
    assert_reload_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_on || resync) |=> !settled);
endmodule

// File: rtl/adc_cap_strobe.sv
// Read strobe and capture. On an accepted fall it drives chip-select and
// read-enable low for one clock, then latches word and flag and pulses valid.
// Assumes accepted falls are at least two clocks apart.
module adc_cap_strobe
    import adc_cap_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          keep,
    input  logic [DW-1:0] bus_data,
    input  logic          bus_ovr,
    output logic          cs_n,
    output logic          en_n,
    output logic          valid,
    output logic [DW-1:0] data,
    output logic          ovr
);
    strobe_state_t st;

    // Strobe sequencer and output latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cs_n  <= 1'b1;
            en_n  <= 1'b1;
            valid <= 1'b0;
            data  <= '0;
            ovr   <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (st)
                ST_IDLE: if (keep) begin
                    cs_n <= 1'b0;
                    en_n <= 1'b0;
                    st   <= ST_READ;
                end
                default: begin
                    data  <= bus_data;
                    ovr   <= bus_ovr;
                    valid <= 1'b1;
                    cs_n  <= 1'b1;
                    en_n  <= 1'b1;
                    st    <= ST_IDLE;
                end
            endcase
        end
    end

    // R2: the strobe lasts exactly one clock
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> cs_n);
    // R3: valid always follows a strobe cycle
    assert_valid_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(!cs_n && !en_n));
endmodule

// File: rtl/adc_cap_syncgen.sv
// Sync pulse generator. A request while idle starts a pulse of LEN clocks;
// the output flop runs on the falling clock edge so the converter sees the
// release there. Requests during a pulse are dropped.
module adc_cap_syncgen #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic active,
    output logic sync_n
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;

    // Pulse length counter
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (cnt != '0)           cnt <= cnt - 1'b1;
        else if (req)                 cnt <= CW'(LEN);
    end

    assign active = (cnt != '0);

    // Falling-edge output register for the sync line
    always_ff @(negedge clk) begin
        if (!rst_n) sync_n <= 1'b1;
        else        sync_n <= ~active;
    end

    // R8: no pulse starts without a request
    assert_sync_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !req) |=> !active);
    // R8: a running pulse is not cut short
    assert_sync_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt > 1) |=> active);
endmodule

// File: rtl/adc_capture.sv
// Top of the converter capture block: data-ready edge detection, settling
// blanking, read strobe with capture, and sync pulse generation. Assumes
// the converter runs from the same clock as this block.
module adc_capture #(
    parameter int DW       = 16,
    parameter int STAGES   = 2,
    parameter int N_NORM   = 55,
    parameter int N_DBL    = 13,
    parameter int N_PWR    = 100,
    parameter int SYNC_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rdy_n,
    input  logic [DW-1:0] bus_data,
    input  logic          bus_ovr,
    input  logic          dbl_rate,
    input  logic          pwr_on,
    input  logic          sync_req,
    output logic          rd_cs_n,
    output logic          rd_en_n,
    output logic          cnv_sync_n,
    output logic          smp_valid,
    output logic [DW-1:0] smp_data,
    output logic          smp_ovr,
    output logic          settled
);
    logic fall, fall_ok, keep, sync_act, mode_q, resync;

    // Remembered rate mode for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= dbl_rate;
        else        mode_q <= dbl_rate;
    end

    assign fall_ok = fall && !sync_act;
    assign resync  = sync_act || (dbl_rate != mode_q);

    adc_cap_edge #(.STAGES(STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .rdy_n(rdy_n), .fall(fall)
    );

    adc_cap_blank #(.N_NORM(N_NORM), .N_DBL(N_DBL), .N_PWR(N_PWR)) u_blank (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .resync(resync),
        .dbl_rate(dbl_rate), .fall(fall_ok), .settled(settled), .keep(keep)
    );

    adc_cap_strobe #(.DW(DW)) u_strobe (
        .clk(clk), .rst_n(rst_n), .keep(keep), .bus_data(bus_data),
        .bus_ovr(bus_ovr), .cs_n(rd_cs_n), .en_n(rd_en_n),
        .valid(smp_valid), .data(smp_data), .ovr(smp_ovr)
    );

    adc_cap_syncgen #(.LEN(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .req(sync_req),
        .active(sync_act), .sync_n(cnv_sync_n)
    );

    // R3: valid is a single-clock pulse
    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);
    // R10: no read strobe follows while the sync line is low
    assert_no_read_in_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_sync_n |=> rd_cs_n);
endmodule

// File: tb/adc_capture_tb.sv
`timescale 1ns/100ps
module adc_capture_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rdy_n = 1'b1;
    logic [15:0] bus_data = '0;
    logic        bus_ovr = 1'b0;
    logic        dbl_rate = 1'b0;
    logic        pwr_on = 1'b1;
    logic        sync_req = 1'b0;
    logic        rd_cs_n, rd_en_n, cnv_sync_n, smp_valid, smp_ovr, settled;
    logic [15:0] smp_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    adc_capture u_dut (
        .clk(clk), .rst_n(rst_n), .rdy_n(rdy_n), .bus_data(bus_data),
        .bus_ovr(bus_ovr), .dbl_rate(dbl_rate), .pwr_on(pwr_on),
        .sync_req(sync_req), .rd_cs_n(rd_cs_n), .rd_en_n(rd_en_n),
        .cnv_sync_n(cnv_sync_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_ovr(smp_ovr), .settled(settled)
    );

    // One clock step: sample and drive 1 ns after the rising edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One data-ready period of 8 clocks; checks strobe, capture and settled
    task automatic rdy_cycle(input logic [15:0] d, input logic o, input bit keep,
                             input bit exp_settled, input string tag);
        bus_data = d;
        bus_ovr  = o;
        rdy_n    = 1'b0;
        tick(); tick(); tick();
        chk({tag, " R2 cs_n"}, rd_cs_n, !keep);
        chk({tag, " R2 rd_n"}, rd_en_n, !keep);
        tick();
        chk({tag, " R3 valid"}, smp_valid, keep);
        if (keep) begin
            chk({tag, " R3 data"}, smp_data, d);
            chk({tag, " R9 ovr"}, smp_ovr, o);
        end
        chk({tag, " settled"}, settled, exp_settled);
        rdy_n = 1'b1;
        tick();
        chk({tag, " R3 valid drop"}, smp_valid, 0);
        chk({tag, " R2 cs release"}, rd_cs_n, 1);
        tick(); tick(); tick();
    endtask

    task automatic blank_run(input int n, input string tag);
        for (int i = 0; i < n; i++)
            rdy_cycle(16'h5A00 + 16'(i), 1'b0, 1'b0, (i == n - 1), tag);
        rdy_cycle(16'h1234, 1'b0, 1'b1, 1'b1, {tag, " first kept"});
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        tick(); tick(); tick();
        chk("R1 cs_n", rd_cs_n, 1);
        chk("R1 rd_n", rd_en_n, 1);
        chk("R1 sync_n", cnv_sync_n, 1);
        chk("R1 valid", smp_valid, 0);
        chk("R1 settled", settled, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 settled after", settled, 0);
        chk("R1 cs after", rd_cs_n, 1);
    endtask

    task automatic test_powerup();
        blank_run(100, "R4 reset");
        rdy_cycle(16'h7FFF, 1'b1, 1'b1, 1'b1, "R9 pos full");
        rdy_cycle(16'h8000, 1'b1, 1'b1, 1'b1, "R9 neg full");
        rdy_cycle(16'hFFFF, 1'b0, 1'b1, 1'b1, "R3 minus one");
        rdy_cycle(16'h0001, 1'b0, 1'b1, 1'b1, "R3 plus one");
    endtask

    // Sync pulse with a second request and optional data-ready fall inside
    task automatic do_sync(input bit with_rdy, input string tag);
        sync_req = 1'b1;
        tick();
        sync_req = 1'b0;
        chk({tag, " R8 T1 high"}, cnv_sync_n, 1);
        tick();
        chk({tag, " R8 T2 low"}, cnv_sync_n, 0);
        if (with_rdy) begin
            bus_data = 16'hDEAD;
            rdy_n    = 1'b0;
        end
        tick();
        chk({tag, " R10 cs T3"}, rd_cs_n, 1);
        sync_req = 1'b1;
        tick();
        sync_req = 1'b0;
        rdy_n    = 1'b1;
        chk({tag, " R10 cs T4"}, rd_cs_n, 1);
        tick();
        chk({tag, " R8 T5 low"}, cnv_sync_n, 0);
        chk({tag, " R10 cs T5"}, rd_cs_n, 1);
        tick();
        chk({tag, " R8 T6 high"}, cnv_sync_n, 1);
        chk({tag, " R10 valid"}, smp_valid, 0);
        chk({tag, " unsettled"}, settled, 0);
        tick();
        chk({tag, " R8 no restart"}, cnv_sync_n, 1);
        tick(); tick();
    endtask

    task automatic test_sync_norm();
        dbl_rate = 1'b0;
        do_sync(1'b0, "R5 sync");
        blank_run(55, "R5 norm");
    endtask

    task automatic test_sync_dbl();
        dbl_rate = 1'b1;
        tick(); tick();
        do_sync(1'b1, "R6 sync");
        blank_run(13, "R6 dbl R10");
    endtask

    task automatic test_mode();
        dbl_rate = 1'b0;
        tick();
        chk("R7 settled clear", settled, 0);
        tick(); tick();
        blank_run(55, "R7 to norm");
        dbl_rate = 1'b1;
        tick(); tick();
        blank_run(13, "R7 to dbl");
    endtask

    task automatic test_pwr();
        pwr_on = 1'b0;
        tick(); tick(); tick();
        chk("R4 pd settled", settled, 0);
        pwr_on = 1'b1;
        tick(); tick();
        blank_run(100, "R4 pwr exit");
    endtask

    initial begin
        tick();
        test_reset();
        test_powerup();
        test_sync_norm();
        test_sync_dbl();
        test_mode();
        test_pwr();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule